// File: doc/BRIEF.md
# PLL Lock-Failure Bad-Lane Marker

This block runs once the PHY reset sequence has finished. It turns data-lane PLL lock failures into bad-lane marks in a per-rank bitmap store. When `start` is pulsed, it captures a 16-bit lock-status word for each of the two ports, the functional-DIMM flags and the rank count of each DIMM. It then visits port 0 before port 1, DIMM 0 before DIMM 1 within a port, and each rank in ascending order. Every lock PLL that has not locked condemns a fixed pair of bytes in the 10-byte bitmap of each rank on that port.

For each rank the block reads the stored bitmap, ORs in the condemned bytes, and writes the entry back only if the merge changed it. Marks already present are therefore kept, and the store sees no redundant writes. The store is external. It is reached through a request channel (`req_valid`/`req_ready`) and a read-response channel (`rsp_valid`/`rsp_ready`), and either channel may stall for any number of cycles. A request, once raised, holds its kind, address and data until it is accepted. `rsp_ready` is high only while a read is outstanding. When the walk ends, `done` pulses for one cycle.

Top module: `bmap_marker`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are low.
- R2: Units are visited in the order port 0 DIMM 0, port 0 DIMM 1, port 1 DIMM 0, port 1 DIMM 1, with ranks in ascending order. The store address is {port, dimm, rank[1:0]}, with the port in bit 3.
- R3: The functional flag of a unit is `dimm_ok` bit 7 for port 0 DIMM 0, bit 6 for port 0 DIMM 1, bit 3 for port 1 DIMM 0 and bit 2 for port 1 DIMM 1. The other bits are ignored. A unit whose flag is clear gets no store access.
- R4: `rank_cnt` field u, bits [3u+2:3u] with u = 2·port + dimm, gives the rank count of unit u (0 to 4). Ranks 0 to count−1 are visited, and a count of zero means the unit gets no access.
- R5: Each visited rank gets exactly one read, and that read comes before any write to the same rank.
- R6: Lock bit k (k = 0..4) of a port is status bit 15−k. If it is clear, bytes 2k and 2k+1 of the bitmap are written as 0xFF, where byte j is bits [8j+7:8j]. All other bytes keep their stored value.
- R7: A write is issued for a rank only when the merged bitmap differs from the stored one.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_write`, `req_addr` and `req_wdata` stay unchanged.
- R9: `done` is high for exactly one cycle after the last access. `busy` is high from the cycle after `start` is accepted until the `done` cycle, inclusive.
- R10: `start` is ignored while `busy` is high. The status words, flags and rank counts are sampled only when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| lock_p0 | input | 16 | Port 0 lock-status word, lock bit k at bit 15−k |
| lock_p1 | input | 16 | Port 1 lock-status word |
| dimm_ok | input | 8 | Functional-DIMM flags |
| rank_cnt | input | 12 | Four 3-bit rank counts |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| req_valid | output | 1 | Store request valid |
| req_ready | input | 1 | Store accepts request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 4 | Store entry {port, dimm, rank} |
| req_wdata | output | 80 | Merged bitmap for writes |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Block waits for read data |
| rsp_data | input | 80 | Stored bitmap read back |

## Verification
A corrupted cursor shows up at the very next accepted request as a wrong address or a wrong order. A bad lock-bit or functional-flag select shows up as a missing or extra access within the same walk. A merge or change-detect error appears on the first write, either as wrong `req_wdata` or as a write issued where none belongs (or none where one does). The final store contents reflect it at `done`. A state machine that loses a response or a stall shows up as a request that changes while stalled, or as a `done` that never arrives within the per-walk timeout.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int PORTS = 2;
  localparam int DIMMS = 2;
  localparam int UNITS = PORTS * DIMMS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WRREQ,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/bmap_fail_mask.sv
module bmap_fail_mask #(
  parameter int NUM_PLL = 5,
  parameter int STAT_W  = 16,
  localparam int DATA_W = 16 * NUM_PLL
) (
  input  logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] mask
);
  // each unlocked PLL condemns two adjacent bytes
  for (genvar k = 0; k < NUM_PLL; k++) begin : g_pll
    assign mask[16*k +: 16] = {16{~status[STAT_W-1-k]}};
  end
endmodule

// File: rtl/bmap_merge.sv
module bmap_merge #(
  parameter int DATA_W = 80
) (
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] fail,
  output logic [DATA_W-1:0] merged,
  output logic              changed
);
  assign merged  = stored | fail;
  assign changed = |(fail & ~stored);
endmodule

// File: rtl/bmap_cursor.sv
module bmap_cursor #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_rank,
  input  logic             step_unit,
  output logic             port,
  output logic             dimm,
  output logic [CNT_W-1:0] rank,
  output logic             last_unit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port <= 1'b0;
      dimm <= 1'b0;
      rank <= '0;
    end else if (clear) begin
      port <= 1'b0;
      dimm <= 1'b0;
      rank <= '0;
    end else if (step_unit) begin
      {port, dimm} <= {port, dimm} + 2'd1;
      rank         <= '0;
    end else if (step_rank) begin
      rank <= rank + 1'b1;
    end
  end

  assign last_unit = port & dimm;

  // R2: the walk advances along exactly one axis per cycle
  assert_one_axis_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_rank && step_unit));
  // R2: the unit cursor only moves forward
  assert_unit_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_unit && !clear |=> {port, dimm} == $past({port, dimm}) + 2'd1);
endmodule

// File: rtl/bmap_marker.sv
module bmap_marker
  import bmap_pkg::*;
#(
  parameter int NUM_PLL   = 5,
  parameter int STAT_W    = 16,
  parameter int MAX_RANKS = 4,
  localparam int DATA_W   = 16 * NUM_PLL,
  localparam int RANK_W   = $clog2(MAX_RANKS),
  localparam int CNT_W    = $clog2(MAX_RANKS + 1),
  localparam int ADDR_W   = RANK_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [STAT_W-1:0]      lock_p0,
  input  logic [STAT_W-1:0]      lock_p1,
  input  logic [7:0]             dimm_ok,
  input  logic [UNITS*CNT_W-1:0] rank_cnt,
  output logic                   busy,
  output logic                   done,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_write,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [DATA_W-1:0]      req_wdata,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [DATA_W-1:0]      rsp_data
);
  walk_state_t state, state_nx;

  logic [STAT_W-1:0]      stat0_q, stat1_q;
  logic [7:0]             ok_q;
  logic [UNITS*CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0]      merged_q;

  logic             cur_port, cur_dimm, last_unit;
  logic [CNT_W-1:0] cur_rank, cur_cnt;
  logic [1:0]       unit_idx;
  logic             unit_ok, rank_live;
  logic             clear, step_rank, step_unit;
  logic [DATA_W-1:0] fail_mask, merged;
  logic              changed;

  bmap_cursor #(.CNT_W(CNT_W)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .step_rank (step_rank),
    .step_unit (step_unit),
    .port      (cur_port),
    .dimm      (cur_dimm),
    .rank      (cur_rank),
    .last_unit (last_unit)
  );

  bmap_fail_mask #(.NUM_PLL(NUM_PLL), .STAT_W(STAT_W)) u_mask (
    .status (cur_port ? stat1_q : stat0_q),
    .mask   (fail_mask)
  );

  bmap_merge #(.DATA_W(DATA_W)) u_merge (
    .stored  (rsp_data),
    .fail    (fail_mask),
    .merged  (merged),
    .changed (changed)
  );

  // flag positions: p0d0=7, p0d1=6, p1d0=3, p1d1=2
  assign unit_idx  = {cur_port, cur_dimm};
  assign unit_ok   = ok_q[{~cur_port, 1'b1, ~cur_dimm}];
  assign cur_cnt   = cnt_q[int'(unit_idx)*CNT_W +: CNT_W];
  assign rank_live = unit_ok && (cur_rank < cur_cnt);

  always_comb begin
    state_nx  = state;
    clear     = 1'b0;
    step_rank = 1'b0;
    step_unit = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        clear    = 1'b1;
        state_nx = ST_CHECK;
      end
      ST_CHECK: begin
        if (rank_live)      state_nx = ST_RDREQ;
        else if (last_unit) state_nx = ST_DONE;
        else                step_unit = 1'b1;
      end
      ST_RDREQ: if (req_ready) state_nx = ST_RDWAIT;
      ST_RDWAIT: if (rsp_valid) begin
        if (changed) state_nx = ST_WRREQ;
        else begin
          step_rank = 1'b1;
          state_nx  = ST_CHECK;
        end
      end
      ST_WRREQ: if (req_ready) begin
        step_rank = 1'b1;
        state_nx  = ST_CHECK;
      end
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      stat0_q  <= '0;
      stat1_q  <= '0;
      ok_q     <= '0;
      cnt_q    <= '0;
      merged_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && start) begin
        stat0_q <= lock_p0;
        stat1_q <= lock_p1;
        ok_q    <= dimm_ok;
        cnt_q   <= rank_cnt;
      end
      if (state == ST_RDWAIT && rsp_valid) merged_q <= merged;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign req_valid = (state == ST_RDREQ) || (state == ST_WRREQ);
  assign req_write = (state == ST_WRREQ);
  assign req_addr  = {cur_port, cur_dimm, cur_rank[RANK_W-1:0]};
  assign req_wdata = merged_q;
  assign rsp_ready = (state == ST_RDWAIT);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write) && $stable(req_addr)
                                && $stable(req_wdata));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_func_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> unit_ok);
  assert_rank_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cur_rank < cur_cnt);
  assert_wr_holds_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> (req_wdata & fail_mask) == fail_mask);
  assert_rd_before_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_write) |-> $past(rsp_valid && rsp_ready));
endmodule

// File: tb/bmap_marker_bench.sv
module bmap_marker_bench;
  localparam int DATA_W = 80;
  localparam int ADDR_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] lock_p0 = '0, lock_p1 = '0;
  logic [7:0]  dimm_ok = '0;
  logic [11:0] rank_cnt = '0;
  logic busy, done, req_valid, req_write, rsp_ready;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_data = '0;

  bmap_marker u_bmap_marker (
    .clk(clk), .rst_n(rst_n), .start(start), .lock_p0(lock_p0), .lock_p1(lock_p1),
    .dimm_ok(dimm_ok), .rank_cnt(rank_cnt), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [DATA_W-1:0] store [16];
  logic              exp_wr   [64];
  logic [ADDR_W-1:0] exp_addr [64];
  logic [DATA_W-1:0] exp_data [64];
  logic [DATA_W-1:0] exp_store [16];
  int n_exp = 0, exp_idx = 0, done_cnt = 0;
  bit stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit pend = 1'b0, rsp_fire = 1'b0, hold_prev = 1'b0, h_wr = 1'b0;
  logic [ADDR_W-1:0] pend_addr = '0, h_addr = '0;
  logic [DATA_W-1:0] h_data = '0;

  task automatic chk(input bit ok, input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [DATA_W-1:0] fail_bytes(input logic [15:0] s);
    logic [DATA_W-1:0] m = '0;
    for (int k = 0; k < 5; k++) if (!s[15-k]) m[16*k +: 16] = 16'hFFFF;
    return m;
  endfunction

  task automatic init_store();
    for (int a = 0; a < 16; a++)
      store[a] = {8'(a), 56'h0, (a % 3 == 0) ? 16'hFFFF : 16'h00A5};
  endtask

  task automatic build_expected(input logic [15:0] s0, s1, input logic [7:0] f,
                                input logic [11:0] rc);
    n_exp = 0;
    for (int a = 0; a < 16; a++) exp_store[a] = store[a];
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 2; d++) begin
        bit ok = (p == 0) ? f[7-d] : f[3-d];
        int n = int'(rc[(p*2+d)*3 +: 3]);
        if (ok) for (int r = 0; r < n; r++) begin
          logic [ADDR_W-1:0] a = {1'(p), 1'(d), 2'(r)};
          logic [DATA_W-1:0] nw = exp_store[a] | fail_bytes(p == 0 ? s0 : s1);
          exp_wr[n_exp] = 1'b0; exp_addr[n_exp] = a; exp_data[n_exp] = '0; n_exp++;
          if (nw != exp_store[a]) begin
            exp_wr[n_exp] = 1'b1; exp_addr[n_exp] = a; exp_data[n_exp] = nw; n_exp++;
            exp_store[a] = nw;
          end
        end
      end
  endtask

  // store model, handshake monitor and transaction checker
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      if (hold_prev)
        chk(req_valid && req_write == h_wr && req_addr == h_addr && req_wdata == h_data,
            "R8 request changed while stalled", {76'h0, req_addr}, {76'h0, h_addr});
      if (rsp_fire) begin rsp_valid = 1'b0; pend = 1'b0; end
      if (pend && !rsp_valid && (!stall_en || lfsr[3])) begin
        rsp_valid = 1'b1;
        rsp_data  = store[pend_addr];
      end
      rsp_fire  = rsp_valid && rsp_ready;
      req_ready = !stall_en || lfsr[0];
      if (req_valid && req_ready) begin
        if (exp_idx >= n_exp)
          chk(1'b0, "R2 unexpected extra access", {76'h0, req_addr}, '0);
        else begin
          chk(req_write == exp_wr[exp_idx], "R5/R7 access kind",
              {79'h0, req_write}, {79'h0, exp_wr[exp_idx]});
          chk(req_addr == exp_addr[exp_idx], "R2 access order/address",
              {76'h0, req_addr}, {76'h0, exp_addr[exp_idx]});
          if (exp_wr[exp_idx])
            chk(req_wdata == exp_data[exp_idx], "R6 merged write data",
                req_wdata, exp_data[exp_idx]);
        end
        exp_idx++;
        if (req_write) store[req_addr] = req_wdata;
        else begin pend = 1'b1; pend_addr = req_addr; end
      end
      hold_prev = req_valid && !req_ready;
      h_wr = req_write; h_addr = req_addr; h_data = req_wdata;
      if (done) done_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_case(input logic [15:0] s0, s1, input logic [7:0] f,
                          input logic [11:0] rc, input bit fresh, input bit stall,
                          input bit poke, input string tag);
    int cnt = 0;
    bit same = 1'b1;
    if (fresh) init_store();
    build_expected(s0, s1, f, rc);
    @(negedge clk);
    stall_en = stall; exp_idx = 0; done_cnt = 0;
    lock_p0 = s0; lock_p1 = s1; dimm_ok = f; rank_cnt = rc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: inputs change after acceptance; only the sampled copy counts
    lock_p0 = ~s0; lock_p1 = ~s1; dimm_ok = ~f; rank_cnt = 12'o4444;
    @(negedge clk);
    if (poke && busy) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0 && cnt < 3000) begin @(negedge clk); cnt++; end
    repeat (3) @(negedge clk);
    #1;
    chk(done_cnt == 1 && !busy, {"R9 single done pulse, idle after (", tag, ")"},
        DATA_W'(done_cnt), 80'd1);
    chk(exp_idx == n_exp, {"access count (", tag, ")"}, DATA_W'(exp_idx), DATA_W'(n_exp));
    for (int a = 0; a < 16; a++) if (store[a] != exp_store[a]) same = 1'b0;
    chk(same, {"R6 final store contents (", tag, ")"}, '0, '0);
  endtask

  initial begin
    init_store();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !req_valid, "R1 reset state", {77'h0, busy, done, req_valid}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !req_valid, "R1 idle after reset", {77'h0, busy, done, req_valid}, '0);

    // all locked: reads only
    run_case(16'hF800, 16'hF800, 8'hCC, 12'o4444, 1, 0, 0, "R7 no failure, no write");
    // one PLL of port 0 failed
    run_case(16'h7800, 16'hF800, 8'hCC, 12'o4444, 1, 1, 0, "R6 single PLL");
    // everything failed, then the same again: second pass writes nothing
    run_case(16'h0000, 16'h0000, 8'hCC, 12'o1234, 1, 1, 0, "R6 all PLLs");
    run_case(16'h0000, 16'h0000, 8'hCC, 12'o1234, 0, 1, 0, "R7 repeat walk");
    // zero ranks everywhere
    run_case(16'h0000, 16'h0000, 8'hFF, 12'o0000, 1, 0, 0, "R4 zero ranks");
    // start pulsed while busy
    run_case(16'h5000, 16'hA800, 8'hCC, 12'o4444, 1, 1, 1, "R10 start while busy");

    // lock-pattern sweep: 32 patterns on port 0, complement on port 1
    for (int v = 0; v < 32; v++)
      run_case({5'(v), 11'h0}, {~5'(v), 11'h0}, 8'hCC, 12'o4321, 1, v[0], 0,
               "R6 lock sweep");
    // functional-flag sweep with the ignored bits set
    for (int v = 0; v < 16; v++)
      run_case(16'h0000, 16'hA800, {v[3], v[2], 2'b11, v[1], v[0], 2'b11}, 12'o2041,
               1, v[1], 0, "R3 flag sweep");
    // rank-count sweep for port 0 DIMM 0
    for (int v = 0; v < 5; v++)
      run_case(16'h3000, 16'hF000, 8'h80, {9'o000, 3'(v)}, 1, 1, 0, "R4 rank sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule